// File: doc/BRIEF.md
# Dual-Element Scan Stage Register

This block is one stage register of a handshake pipeline, made of per-bit scan cells so that it can be observed and controlled during manufacturing test. Each cell has two storage elements: a primary element that holds scan or test stimulus and a secondary element that holds the captured pipeline data. An output multiplexer chooses which element drives the parallel output. The cells are modelled with a free-running clock and level-style enables instead of transparent latches. Each enable is sampled at a rising clock edge and takes effect at that edge.

Three modes are selected by the inputs. In normal mode, a data enable loads the parallel input into the secondary elements, which drive the output. In scan mode, the cells form a serial chain that behaves like master-slave flip-flops. While the scan clock enable is high, each primary element loads from its upstream neighbour. The cycle in which the scan clock enable drops moves every primary value into its secondary element. In test mode, the primary elements hold an applied vector and drive the output. A stage request, given on the data enable, captures the response into the secondary elements and leaves the vector intact. The captured response can then be shifted out.

Top module: `scan_stage_reg`

## Requirements
- R1: While reset is asserted, the parallel output, the serial output and the error flag are all 0, whatever the test select input is.
- R2: When the test select is 0, the scan clock enable is 0, the previous cycle was not a scan-high cycle and the data enable is 1, the parallel output shows the sampled parallel input after the next rising edge.
- R3: When the data enable and the scan clock enable are both 0 and no scan fall is pending, the secondary elements hold, so the parallel output stays stable while the test select stays 0.
- R4: In a cycle where the scan clock enable is 1, the primary element of bit 0 loads the serial input and the primary element of bit i loads the secondary element of bit i-1. While the scan phase is high, the serial output shows the primary element of bit W-1.
- R5: In the first cycle after a scan-high cycle with the scan clock enable at 0, every secondary element takes its primary value. The serial output keeps the same value across this transfer, and afterwards it shows the secondary element of bit W-1.
- R6: When the test select is 1, the parallel output shows the primary elements. When it is 0, the parallel output shows the secondary elements.
- R7: In test mode, a data-enable capture loads the parallel input into the secondary elements and leaves the primary elements unchanged. The output stays equal to the applied vector while the test select is 1, and switching the test select to 0 then shows the captured data.
- R8: If the scan clock enable and the data enable are both 1 at a rising edge, the shift takes priority, nothing is captured, and the error flag is 1 after that edge.
- R9: Feeding an alternating 0,1,0,1... sequence through W or more shift pairs (one high cycle then one low cycle) produces the same sequence on the serial output, delayed by W-1 pairs and read after each low cycle. The first bit shifted in leaves first.
- R10: The error flag is 0 after any rising edge at which the scan clock enable and the data enable were not both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_i | input | W | Parallel data from upstream logic |
| den_i | input | 1 | Data enable; acts as the capture request in test mode |
| sck_i | input | 1 | Scan clock enable (shift phase) |
| tsel_i | input | 1 | Test mode select; 1 routes the primary elements to the output |
| sin_i | input | 1 | Serial scan input to bit 0 |
| dout_o | output | W | Parallel stage output |
| sout_o | output | 1 | Serial scan output from bit W-1 |
| err_o | output | 1 | Scan clock enable and data enable were asserted together |

## Verification
Directed sequences cover each mode on its own. A plain load-and-hold separates capture from retention. A scan load, test-mode capture and readback shows that the vector and the response sit in different elements. An alternating-bit stream through the whole chain shows the shift order and the bit-to-bit linkage. Collisions of the scan clock enable with the data enable check the shift priority and the error flag. Seeded random mixes of all inputs, compared each cycle against a reference model in the bench, cover mode switches in the middle of a scan pair and a capture right after a scan fall.

// File: rtl/scanreg_pkg.sv
package scanreg_pkg;

    // Per-cycle actions decoded once and shared by all cells
    typedef struct packed {
        logic load_first;   // primary element takes its chain input
        logic xfer;         // secondary element takes the primary value
        logic capture;      // secondary element takes the parallel input
        logic phase_hi;     // scan phase currently high
    } cell_ctrl_t;

    typedef struct packed {
        logic phase;
        logic err;
    } ctrl_state_t;

    typedef struct packed {
        logic first;
        logic second;
    } cell_state_t;

endpackage

// File: rtl/scanreg_ctrl.sv
module scanreg_ctrl
    import scanreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       den_i,
    output cell_ctrl_t ctrl_o,
    output logic       err_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = sck_i;
        st_d.err   = sck_i & den_i;

        ctrl_o.load_first = sck_i;
        ctrl_o.xfer       = ~sck_i & st_q.phase;
        ctrl_o.capture    = ~sck_i & ~st_q.phase & den_i;
        ctrl_o.phase_hi   = st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

endmodule

// File: rtl/scanreg_cell.sv
module scanreg_cell
    import scanreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_ctrl_t ctrl_i,
    input  logic       tsel_i,
    input  logic       d_i,
    input  logic       chain_i,
    output logic       q_o,
    output logic       chain_o,
    output logic       so_o
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_i.load_first)   st_d.first  = chain_i;
        else if (ctrl_i.xfer)    st_d.second = st_q.first;
        else if (ctrl_i.capture) st_d.second = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o     = tsel_i ? st_q.first : st_q.second;
    assign chain_o = st_q.second;
    assign so_o    = ctrl_i.phase_hi ? st_q.first : st_q.second;

endmodule

// File: rtl/scan_stage_reg.sv
module scan_stage_reg
    import scanreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    input  logic         den_i,
    input  logic         sck_i,
    input  logic         tsel_i,
    input  logic         sin_i,
    output logic [W-1:0] dout_o,
    output logic         sout_o,
    output logic         err_o
);

    localparam int LAST = W - 1;

    cell_ctrl_t   ctrl;
    logic [W-1:0] chain_in;
    logic [W-1:0] chain_out;
    logic [W-1:0] so_bits;

    scanreg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .den_i  (den_i),
        .ctrl_o (ctrl),
        .err_o  (err_o)
    );

    assign chain_in[0] = sin_i;

    genvar g;
    generate
        for (g = 1; g < W; g++) begin : g_link
            assign chain_in[g] = chain_out[g-1];
        end
        for (g = 0; g < W; g++) begin : g_cell
            scanreg_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .ctrl_i  (ctrl),
                .tsel_i  (tsel_i),
                .d_i     (din_i[g]),
                .chain_i (chain_in[g]),
                .q_o     (dout_o[g]),
                .chain_o (chain_out[g]),
                .so_o    (so_bits[g])
            );
        end
    endgenerate

    assign sout_o = so_bits[LAST];

endmodule

// File: rtl/scanreg_checker.sv
module scanreg_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] din_i,
    input logic         den_i,
    input logic         sck_i,
    input logic         tsel_i,
    input logic [W-1:0] dout_o,
    input logic         sout_o,
    input logic         err_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (dout_o == '0 && !sout_o && !err_o)); // R1

    AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (den_i && !sck_i && !$past(sck_i) && !tsel_i) |=> (tsel_i || dout_o == $past(din_i))); // R2

    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_i && !sck_i && !$past(sck_i) && !tsel_i) |=> (tsel_i || $stable(dout_o))); // R3

    AST_FALL_SOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_i && $past(sck_i)) |=> $stable(sout_o)); // R5

    AST_TEST_VECTOR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel_i && !sck_i) |=> (!tsel_i || $stable(dout_o))); // R7

    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_i && den_i) |=> err_o); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_i && den_i) |=> !err_o); // R10

endmodule

bind scan_stage_reg scanreg_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (din_i),
    .den_i  (den_i),
    .sck_i  (sck_i),
    .tsel_i (tsel_i),
    .dout_o (dout_o),
    .sout_o (sout_o),
    .err_o  (err_o)
);

// File: tb/scan_stage_reg_test.sv
module scan_stage_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         den = 1'b0, sck = 1'b0, tsel = 1'b0, sin = 1'b0;
    logic [W-1:0] dout;
    logic         sout, err;

    int total = 0;
    int fails = 0;

    // reference state
    logic [W-1:0] mf = '0, ms = '0;
    logic         mph = 1'b0, merr = 1'b0;

    always #5 clk = ~clk;

    scan_stage_reg #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .din_i(din), .den_i(den), .sck_i(sck),
        .tsel_i(tsel), .sin_i(sin), .dout_o(dout), .sout_o(sout), .err_o(err)
    );

    task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_dout(input logic ts);
        return ts ? mf : ms;
    endfunction

    function automatic logic exp_sout();
        return mph ? mf[W-1] : ms[W-1];
    endfunction

    task automatic model_edge();
        logic [W-1:0] of = mf, os = ms;
        if (sck) begin
            mf[0] = sin;
            for (int i = 1; i < W; i++) mf[i] = os[i-1];
        end else if (mph) begin
            ms = of;
        end else if (den) begin
            ms = din;
        end
        mph  = sck;
        merr = sck & den;
    endtask

    task automatic cyc(input logic [W-1:0] d, input logic de, input logic sc,
                       input logic ts, input logic si, input string tag);
        @(negedge clk);
        din = d; den = de; sck = sc; tsel = ts; sin = si;
        @(posedge clk);
        model_edge();
        #1;
        chk({tag, " dout"}, dout, exp_dout(ts));
        chk({tag, " sout"}, W'(sout), W'(exp_sout()));
        chk(merr ? "R8 err" : "R10 err", W'(err), W'(merr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [W-1:0] vec, rsp;
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (2) @(posedge clk);
        din = '1; tsel = 1'b1; #1;
        chk("R1 dout tsel1", dout, '0);
        tsel = 1'b0; #1;
        chk("R1 dout", dout, '0);
        chk("R1 sout", W'(sout), '0);
        chk("R1 err", W'(err), '0);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R3: normal load and hold
        cyc(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        chk("R2 direct", dout, 8'hA5);
        cyc(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        chk("R3 direct", dout, 8'hA5);

        // R4/R5/R9: alternating stream through chain
        for (int k = 0; k < 2 * W; k++) begin
            cyc('0, 1'b0, 1'b1, 1'b0, k[0], "R4");
            chk("R4 sout hi", W'(sout), W'(mf[W-1]));
            cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
            if (k >= W - 1) chk("R9 alt", W'(sout), W'((k - (W - 1)) & 1));
        end

        // R6/R7: scan in vector, test-mode capture, read both elements
        vec = 8'h96;
        for (int k = W - 1; k >= 0; k--) begin
            cyc('0, 1'b0, 1'b1, 1'b0, vec[k], "R4");
            cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        end
        cyc('0, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        chk("R6 vector on output", dout, vec);
        rsp = 8'h5E;
        cyc(rsp, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        chk("R7 vector kept", dout, vec);
        cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        chk("R7 captured", dout, rsp);

        // R8 / R10: collision then clear
        cyc(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
        chk("R8 flag", W'(err), W'(1));
        chk("R8 no capture", dout, rsp);
        cyc(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        chk("R10 flag clear", W'(err), '0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] d = W'($urandom);
            logic de = ($urandom % 3) == 0;
            logic sc = ($urandom % 3) == 0;
            logic ts = ($urandom % 4) == 0;
            logic si = $urandom % 2;
            string tag;
            if (sc && de)  tag = "R8";
            else if (sc)   tag = "R4";
            else if (mph)  tag = "R5";
            else if (ts)   tag = "R6";
            else if (de)   tag = "R2";
            else           tag = "R3";
            cyc(d, de, sc, ts, si, tag);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule